// File: doc/BRIEF.md
# Line Direction Histogram Classifier

This block sorts 3x3 binary windows of a line image into one of 24 direction types. It keeps a count of how often each type occurs over a frame. Each window arrives already formed, as a 9-bit pattern with a valid strobe. A combinational table turns the pattern into a 24-bit one-hot increment vector, and each bit of that vector drives one counter in a bank of 24 saturating counters.

A frame opens with a frame-start pulse and closes with a frame-end pulse. Frame-end starts a search that reads one counter per clock and finds the counter with the largest value. The search then reports that type index and its count, and raises a done flag for one cycle. The table contents are a parameter: the 9-bit reference pattern for each type. A system can therefore load its own pattern-to-type mapping, and a test can load a known one.

Top module: `line_dir_hist`

## Requirements
- R1: While rst_ni is low and after it is released, done_o is 0, dom_type_o is 0 and dom_count_o is 0 until the first scan completes.
- R2: A window with win_valid_i high whose win_pat_i equals entry t of DIR_TABLE adds one to the counter of type t. Entry t occupies bits [9t+8:9t].
- R3: A valid window whose pattern equals no table entry changes no counter.
- R4: A window presented with win_valid_i low changes no counter, whatever its pattern.
- R5: frame_start_i clears all 24 counters. A valid window presented in the same cycle counts as the first window of the new frame.
- R6: Counters are 16 bits wide and stop at 65535 instead of wrapping.
- R7: Take the rising edge that samples frame_end_i high while idle. done_o rises on the 24th rising edge after that edge and stays high for exactly one cycle.
- R8: With done_o, dom_type_o gives the type with the largest count and dom_count_o gives that count. On a tie the lowest type index wins, so a frame with no counts reports type 0 and count 0.
- R9: frame_end_i asserted while a scan is running is ignored. It neither restarts the scan nor produces an extra done pulse.
- R10: dom_type_o and dom_count_o hold their values from one done pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_valid_i | input | 1 | Window strobe |
| win_pat_i | input | 9 | 3x3 window pattern |
| frame_start_i | input | 1 | Clears the counters |
| frame_end_i | input | 1 | Starts the argmax scan |
| dom_type_o | output | 5 | Dominant direction type |
| dom_count_o | output | 16 | Count of the dominant type |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Random frames mix patterns that match a table entry, patterns that match none, and matching patterns presented with the strobe low. A wrong winner in these frames separates correct counting from counting that leaks through unmatched or invalid windows. An all-unmatched frame and a frame where two types are tied check the lowest-index rule, including the empty case. A long run of one type past 65535 shows the difference between saturating and wrapping counters. A frame whose first window arrives together with frame-start shows whether the clear discards that window or counts it. Done latency and pulse width are measured on every frame. One frame carries a stray frame-end in the middle of its scan.

// File: rtl/ldh_pkg.sv
package ldh_pkg;
  localparam int unsigned NUM_TYPES = 24;
  localparam int unsigned PAT_W     = 9;
  localparam int unsigned CNT_W     = 16;

  // type 0 -> 9'b000111111, remaining entries distinct by construction
  function automatic logic [NUM_TYPES*PAT_W-1:0] default_table();
    logic [NUM_TYPES*PAT_W-1:0] tbl;
    tbl = '0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      tbl[t*PAT_W +: PAT_W] = 9'h03F ^ PAT_W'(t * 19);
    end
    return tbl;
  endfunction
endpackage

// File: rtl/ldh_lut.sv
module ldh_lut #(
  parameter int unsigned N_TYPES = ldh_pkg::NUM_TYPES,
  parameter int unsigned PAT_W   = ldh_pkg::PAT_W,
  parameter logic [N_TYPES*PAT_W-1:0] DIR_TABLE = ldh_pkg::default_table()
) (
  input  logic [PAT_W-1:0]   pat_i,
  output logic [N_TYPES-1:0] inc_o
);
  for (genvar t = 0; t < N_TYPES; t++) begin : g_cmp
    assign inc_o[t] = (pat_i == DIR_TABLE[t*PAT_W +: PAT_W]);
  end
endmodule

// File: rtl/ldh_cnt_bank.sv
module ldh_cnt_bank #(
  parameter int unsigned N_TYPES = ldh_pkg::NUM_TYPES,
  parameter int unsigned CNT_W   = ldh_pkg::CNT_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic [N_TYPES-1:0]              inc_i,
  output logic [N_TYPES-1:0][CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar t = 0; t < N_TYPES; t++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (clr_i) begin
        cnt_q <= CNT_W'(inc_i[t]);
      end else if (inc_i[t] && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign cnt_o[t] = cnt_q;
  end
endmodule

// File: rtl/ldh_argmax.sv
module ldh_argmax #(
  parameter int unsigned N_TYPES = ldh_pkg::NUM_TYPES,
  parameter int unsigned CNT_W   = ldh_pkg::CNT_W,
  localparam int unsigned IDX_W  = $clog2(N_TYPES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [N_TYPES-1:0][CNT_W-1:0] cnt_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic [CNT_W-1:0]              max_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_TYPES - 1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] ptr_q, best_idx_q, idx_q;
  logic [CNT_W-1:0] best_q, max_q;
  logic [CNT_W-1:0] cur;
  logic             take;
  logic [IDX_W-1:0] nxt_idx;
  logic [CNT_W-1:0] nxt_best;

  always_comb begin
    cur      = cnt_i[ptr_q];
    take     = cur > best_q;  // strict: lowest index keeps a tie
    nxt_idx  = take ? ptr_q : best_idx_q;
    nxt_best = take ? cur : best_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      ptr_q      <= '0;
      best_idx_q <= '0;
      best_q     <= '0;
      idx_q      <= '0;
      max_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q     <= 1'b1;
          ptr_q      <= '0;
          best_idx_q <= '0;
          best_q     <= '0;
        end
      end else begin
        best_idx_q <= nxt_idx;
        best_q     <= nxt_best;
        if (ptr_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          idx_q  <= nxt_idx;
          max_q  <= nxt_best;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
  assign max_o  = max_q;
endmodule

// File: rtl/line_dir_hist.sv
module line_dir_hist #(
  parameter int unsigned N_TYPES = ldh_pkg::NUM_TYPES,
  parameter int unsigned PAT_W   = ldh_pkg::PAT_W,
  parameter int unsigned CNT_W   = ldh_pkg::CNT_W,
  parameter logic [N_TYPES*PAT_W-1:0] DIR_TABLE = ldh_pkg::default_table(),
  localparam int unsigned IDX_W  = $clog2(N_TYPES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_valid_i,
  input  logic [PAT_W-1:0] win_pat_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  output logic [IDX_W-1:0] dom_type_o,
  output logic [CNT_W-1:0] dom_count_o,
  output logic             done_o
);
  logic [N_TYPES-1:0]            lut_inc, cnt_inc;
  logic [N_TYPES-1:0][CNT_W-1:0] cnt;
  logic                          scan_busy;

  ldh_lut #(.N_TYPES(N_TYPES), .PAT_W(PAT_W), .DIR_TABLE(DIR_TABLE)) u_lut (
    .pat_i (win_pat_i),
    .inc_o (lut_inc)
  );

  assign cnt_inc = lut_inc & {N_TYPES{win_valid_i}};

  ldh_cnt_bank #(.N_TYPES(N_TYPES), .CNT_W(CNT_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_start_i),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  ldh_argmax #(.N_TYPES(N_TYPES), .CNT_W(CNT_W)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (frame_end_i),
    .cnt_i   (cnt),
    .busy_o  (scan_busy),
    .done_o  (done_o),
    .idx_o   (dom_type_o),
    .max_o   (dom_count_o)
  );
endmodule

// File: rtl/ldh_chk.sv
module ldh_chk #(
  parameter int unsigned N_TYPES = 24,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned CNT_W   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_end_i,
  input logic             scan_busy,
  input logic             done_o,
  input logic [IDX_W-1:0] dom_type_o,
  input logic [CNT_W-1:0] dom_count_o
);
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_after_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(scan_busy) && !scan_busy));

  // R9
  scan_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scan_busy) |-> $past(frame_end_i));

  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(dom_type_o) && $stable(dom_count_o)));

  // R8
  type_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(dom_type_o) < N_TYPES));
endmodule

bind line_dir_hist ldh_chk #(.N_TYPES(N_TYPES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_end_i (frame_end_i),
  .scan_busy   (scan_busy),
  .done_o      (done_o),
  .dom_type_o  (dom_type_o),
  .dom_count_o (dom_count_o)
);

// File: tb/sim_line_dir_hist.sv
module sim_line_dir_hist;
  localparam int NT = 24;

  function automatic logic [NT*9-1:0] bench_table();
    logic [NT*9-1:0] tbl;
    for (int t = 0; t < NT; t++) tbl[t*9 +: 9] = {3'b111, 6'(t)};
    return tbl;
  endfunction

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       win_valid = 1'b0;
  logic [8:0] win_pat = '0;
  logic       f_start = 1'b0;
  logic       f_end = 1'b0;
  logic [4:0] dom_type;
  logic [15:0] dom_count;
  logic       done;

  line_dir_hist #(.DIR_TABLE(bench_table())) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .win_valid_i(win_valid), .win_pat_i(win_pat),
    .frame_start_i(f_start), .frame_end_i(f_end),
    .dom_type_o(dom_type), .dom_count_o(dom_count), .done_o(done)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int idx; int cnt; int cyc; } exp_t;
  exp_t exp_q[$];
  int ref_cnt[NT];
  int last_idx = 0, last_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int type_of(input logic [8:0] p);
    if (p[8:6] == 3'b111 && p[5:0] < 6'(NT)) return int'(p[5:0]);
    return -1;
  endfunction

  function automatic logic [8:0] pat_of(input int t);
    return {3'b111, 6'(t)};
  endfunction

  function automatic logic [8:0] nomatch();
    logic [8:0] p;
    p = 9'($urandom);
    if (type_of(p) >= 0) p[8] = 1'b0;
    return p;
  endfunction

  task automatic apply(input logic v, input logic [8:0] p, input logic st);
    @(negedge clk);
    win_valid = v; win_pat = p; f_start = st; f_end = 1'b0;
    if (st) for (int t = 0; t < NT; t++) ref_cnt[t] = 0;
    if (v && type_of(p) >= 0 && ref_cnt[type_of(p)] < 65535) ref_cnt[type_of(p)]++;
  endtask

  task automatic idle();
    @(negedge clk);
    win_valid = 1'b0; f_start = 1'b0; f_end = 1'b0;
  endtask

  task automatic close_frame(input bit stray);
    exp_t e;
    e.idx = 0; e.cnt = 0;
    for (int t = 0; t < NT; t++) if (ref_cnt[t] > e.cnt) begin e.cnt = ref_cnt[t]; e.idx = t; end
    @(negedge clk);
    // R10: result unchanged since last done
    chk(int'(dom_type) == last_idx && int'(dom_count) == last_cnt, "R10", int'(dom_type), last_idx);
    win_valid = 1'b0; f_start = 1'b0; f_end = 1'b1;
    e.cyc = cyc;
    exp_q.push_back(e);
    idle();
    for (int i = 0; i < 30; i++) begin
      if (stray && i == 6) begin @(negedge clk); f_end = 1'b1; end  // R9
      else idle();
    end
  endtask

  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_done) chk(!done, "R7 pulse width", int'(done), 0);
      if (done) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 extra done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(dom_type) == e.idx, "R8 type", int'(dom_type), e.idx);
          chk(int'(dom_count) == e.cnt, "R8/R6 count", int'(dom_count), e.cnt);
          chk(cyc - e.cyc == 25, "R7 latency", cyc - e.cyc, 25);
          last_idx = int'(dom_type); last_cnt = int'(dom_count);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) ref_cnt[t] = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(!done, "R1 done", int'(done), 0);
    chk(dom_type == 0, "R1 type", int'(dom_type), 0);
    chk(dom_count == 0, "R1 count", int'(dom_count), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && dom_count == 0, "R1 after release", int'(dom_count), 0);

    // R2/R3/R4: random mixed frames
    for (int f = 0; f < 6; f++) begin
      apply(1'b0, '0, 1'b1);
      for (int i = 0; i < 200 + f * 40; i++) begin
        int k = int'($urandom_range(0, 9));
        int ty = int'($urandom_range(0, (f % 2) ? 5 : NT - 1));
        if (k < 6) apply(1'b1, pat_of(ty), 1'b0);
        else if (k < 8) apply(1'b1, nomatch(), 1'b0);
        else apply(1'b0, pat_of(ty), 1'b0);
      end
      close_frame(f == 2);
    end

    // R3/R4: only unmatched and strobe-low windows -> type 0, count 0
    apply(1'b0, '0, 1'b1);
    for (int i = 0; i < 50; i++) begin
      apply(1'b1, nomatch(), 1'b0);
      apply(1'b0, pat_of(i % NT), 1'b0);
    end
    close_frame(1'b0);

    // R4/R2: type 9 x3 valid, type 2 x10 with strobe low
    apply(1'b0, '0, 1'b1);
    for (int i = 0; i < 3; i++) apply(1'b1, pat_of(9), 1'b0);
    for (int i = 0; i < 10; i++) apply(1'b0, pat_of(2), 1'b0);
    close_frame(1'b0);

    // R8 tie: types 7 and 3 both 4 -> type 3
    apply(1'b0, '0, 1'b1);
    for (int i = 0; i < 4; i++) begin apply(1'b1, pat_of(7), 1'b0); apply(1'b1, pat_of(3), 1'b0); end
    close_frame(1'b0);

    // R5: window with frame start counts into new frame
    apply(1'b1, pat_of(20), 1'b1);
    apply(1'b1, pat_of(20), 1'b0);
    apply(1'b1, pat_of(11), 1'b0);
    close_frame(1'b0);

    // R6: saturation
    apply(1'b0, '0, 1'b1);
    for (int i = 0; i < 65540; i++) apply(1'b1, pat_of(5), 1'b0);
    apply(1'b1, pat_of(6), 1'b0);
    close_frame(1'b0);

    repeat (5) idle();
    chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule